// File: doc/BRIEF.md
# Integer Add-Subtract-Compare Unit

A purely combinational 64-bit integer execution slice for one function group of a RISC datapath. It receives operand A, operand B (already a register value or a zero-extended literal) and a 7-bit function code. It returns a 64-bit result, an integer-overflow trap flag and an illegal-function flag within the same cycle.

The slice covers several families of operation:
- add and subtract at 32-bit (longword) and 64-bit (quadword) width;
- scaled-index forms that multiply A by 4 or 8 before the add or subtract;
- trapping variants that report signed overflow;
- equality, signed and unsigned ordering compares that return 0 or 1;
- a byte-lane unsigned compare that packs eight lane results into a bit mask.

Register access, literal expansion and trap delivery belong to the surrounding pipeline.

Top module: `iasc_top`

## Requirements
- R1: Codes 0x00 (32-bit) and 0x20 (64-bit) return A+B. Every 32-bit form computes on bits 31:0 and copies bit 31 of the result into bits 63:32.
- R2: Codes 0x09 (32-bit) and 0x29 (64-bit) return A-B, wrapping modulo the operation width.
- R3: Codes 0x02/0x0b (32-bit add/sub) and 0x22/0x2b (64-bit add/sub) return (A*4)+B or (A*4)-B.
- R4: Codes 0x12/0x1b (32-bit add/sub) and 0x32/0x3b (64-bit add/sub) return (A*8)+B or (A*8)-B.
- R5: Codes 0x40 (32-bit) and 0x60 (64-bit) return A+B. They raise the overflow flag when A and B share a sign bit and the result sign differs from A's. The sign bit is bit 31 for 32-bit forms and bit 63 for 64-bit forms.
- R6: Codes 0x49 (32-bit) and 0x69 (64-bit) return A-B. They raise the overflow flag when the sign bits of A and B differ and the result sign differs from A's.
- R7: The overflow flag is low for every code except 0x40, 0x60, 0x49 and 0x69. The result is produced for every legal code, whether or not overflow is flagged.
- R8: Code 0x2d returns 1 when all 64 bits of A equal B, else 0.
- R9: Code 0x6d returns 1 when A <= B as signed 64-bit values. Code 0x4d returns 1 when A < B signed. Otherwise both return 0.
- R10: Code 0x3d returns 1 when A <= B as unsigned values. Code 0x1d returns 1 when A < B unsigned. Otherwise both return 0.
- R11: Code 0x0f sets result bit i (i = 0..7) when byte i of A (bits 8i+7:8i) is unsigned >= byte i of B. Result bits 63:8 are zero.
- R12: Any other code raises the illegal flag and returns result 0 with overflow low. Legal codes keep the illegal flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B (register or zero-extended literal) |
| func_i | input | 7 | Function code |
| result_o | output | 64 | Operation result |
| ovf_o | output | 1 | Signed-overflow trap request |
| illegal_o | output | 1 | Unrecognised function code |

## Verification
A trapping add or subtract delivers two things in the same evaluation: the wrapped sum or difference, and the overflow trap request. The sum is written even when the trap fires, so both must be right at once. The bench provokes this with operands at the signed edge of each width, for example 0x7FFFFFFF plus 1, the most negative value minus 1, and mixed-sign pairs that must not trap. It judges the result and the flag together against a behavioural model every clock. The same operand pairs are replayed under the non-trapping codes to confirm the flag stays low while the result is unchanged.

// File: rtl/iasc_pkg.sv
package iasc_pkg;

   typedef enum logic [1:0] {
      FAM_ARITH = 2'd0,
      FAM_CMP   = 2'd1,
      FAM_LANE  = 2'd2,
      FAM_NONE  = 2'd3
   } fam_e;

   typedef enum logic [2:0] {
      CMP_EQ  = 3'd0,
      CMP_SLE = 3'd1,
      CMP_SLT = 3'd2,
      CMP_ULE = 3'd3,
      CMP_ULT = 3'd4
   } cmp_e;

   typedef struct packed {
      fam_e       fam;
      logic       is_long;
      logic       is_sub;
      logic [1:0] shamt;
      logic       trap;
      cmp_e       cmp;
   } dec_t;

endpackage

// File: rtl/iasc_decode.sv
module iasc_decode
   import iasc_pkg::*;
#(
   parameter int FUNC_W = 7
) (
   input  logic [FUNC_W-1:0] func_i,
   output dec_t              dec_o
);

   if (FUNC_W < 7) begin : g_chk_w
      $error("iasc_decode: FUNC_W must be at least 7");
   end

   function automatic dec_t arith(input logic lng, input logic sub,
                                  input logic [1:0] sh, input logic trp);
      dec_t d;
      d.fam     = FAM_ARITH;
      d.is_long = lng;
      d.is_sub  = sub;
      d.shamt   = sh;
      d.trap    = trp;
      d.cmp     = CMP_EQ;
      return d;
   endfunction

   function automatic dec_t cmpop(input cmp_e c);
      dec_t d;
      d.fam     = FAM_CMP;
      d.is_long = 1'b0;
      d.is_sub  = 1'b0;
      d.shamt   = 2'd0;
      d.trap    = 1'b0;
      d.cmp     = c;
      return d;
   endfunction

   always_comb begin
      dec_o = cmpop(CMP_EQ);
      dec_o.fam = FAM_NONE;
      case (func_i)
         // plain add / subtract
         7'h00: dec_o = arith(1'b1, 1'b0, 2'd0, 1'b0);
         7'h20: dec_o = arith(1'b0, 1'b0, 2'd0, 1'b0);
         7'h09: dec_o = arith(1'b1, 1'b1, 2'd0, 1'b0);
         7'h29: dec_o = arith(1'b0, 1'b1, 2'd0, 1'b0);
         // trapping
         7'h40: dec_o = arith(1'b1, 1'b0, 2'd0, 1'b1);
         7'h60: dec_o = arith(1'b0, 1'b0, 2'd0, 1'b1);
         7'h49: dec_o = arith(1'b1, 1'b1, 2'd0, 1'b1);
         7'h69: dec_o = arith(1'b0, 1'b1, 2'd0, 1'b1);
         // scaled by 4
         7'h02: dec_o = arith(1'b1, 1'b0, 2'd2, 1'b0);
         7'h22: dec_o = arith(1'b0, 1'b0, 2'd2, 1'b0);
         7'h0b: dec_o = arith(1'b1, 1'b1, 2'd2, 1'b0);
         7'h2b: dec_o = arith(1'b0, 1'b1, 2'd2, 1'b0);
         // scaled by 8
         7'h12: dec_o = arith(1'b1, 1'b0, 2'd3, 1'b0);
         7'h32: dec_o = arith(1'b0, 1'b0, 2'd3, 1'b0);
         7'h1b: dec_o = arith(1'b1, 1'b1, 2'd3, 1'b0);
         7'h3b: dec_o = arith(1'b0, 1'b1, 2'd3, 1'b0);
         // compares
         7'h2d: dec_o = cmpop(CMP_EQ);
         7'h6d: dec_o = cmpop(CMP_SLE);
         7'h4d: dec_o = cmpop(CMP_SLT);
         7'h3d: dec_o = cmpop(CMP_ULE);
         7'h1d: dec_o = cmpop(CMP_ULT);
         7'h0f: begin
            dec_o = cmpop(CMP_EQ);
            dec_o.fam = FAM_LANE;
         end
         default: ;
      endcase
   end

   // R7
   always_comb begin
      if (dec_o.trap) begin
         trap_arith_chk: assert (dec_o.fam == FAM_ARITH && dec_o.shamt == 2'd0);
      end
   end

endmodule

// File: rtl/iasc_arith.sv
module iasc_arith #(
   parameter int DATA_W = 64,
   parameter int LONG_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              is_long_i,
   input  logic              is_sub_i,
   input  logic [1:0]        shamt_i,
   output logic [DATA_W-1:0] res_o,
   output logic              ovf_o
);

   localparam int EXT_W = DATA_W - LONG_W;

   if (LONG_W >= DATA_W || LONG_W < 2) begin : g_chk_w
      $error("iasc_arith: LONG_W must be between 2 and DATA_W-1");
   end

   logic [DATA_W-1:0] a_sh;
   logic [DATA_W-1:0] b_inv;
   logic [DATA_W-1:0] sum;
   logic              a_s, b_s, r_s;

   always_comb begin
      a_sh  = a_i << shamt_i;
      b_inv = is_sub_i ? ~b_i : b_i;
      sum   = a_sh + b_inv + {{(DATA_W-1){1'b0}}, is_sub_i};
   end

   always_comb begin
      if (is_long_i) begin
         a_s = a_sh[LONG_W-1];
         b_s = b_i[LONG_W-1];
         r_s = sum[LONG_W-1];
         res_o = {{EXT_W{sum[LONG_W-1]}}, sum[LONG_W-1:0]};
      end else begin
         a_s = a_sh[DATA_W-1];
         b_s = b_i[DATA_W-1];
         r_s = sum[DATA_W-1];
         res_o = sum;
      end
      ovf_o = (r_s != a_s) && (is_sub_i ? (a_s != b_s) : (a_s == b_s));
   end

   // R1
   always_comb begin
      if (is_long_i) begin
         long_sext_chk: assert (res_o[DATA_W-1:LONG_W] == {EXT_W{res_o[LONG_W-1]}});
      end
   end

endmodule

// File: rtl/iasc_compare.sv
module iasc_compare
   import iasc_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  cmp_e              sel_i,
   output logic              hit_o
);

   logic eq, ult, slt;

   always_comb begin
      eq  = (a_i == b_i);
      ult = (a_i < b_i);
      slt = (a_i[DATA_W-1] != b_i[DATA_W-1]) ? a_i[DATA_W-1] : ult;
      case (sel_i)
         CMP_EQ:  hit_o = eq;
         CMP_SLE: hit_o = slt | eq;
         CMP_SLT: hit_o = slt;
         CMP_ULE: hit_o = ult | eq;
         CMP_ULT: hit_o = ult;
         default: hit_o = 1'b0;
      endcase
   end

   // R10
   always_comb begin
      if (eq) begin
         eq_not_less_chk: assert (!ult && !slt);
      end
   end

endmodule

// File: rtl/iasc_lane_cmp.sv
module iasc_lane_cmp #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] mask_o
);

   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_chk_lane
      $error("iasc_lane_cmp: DATA_W must be a multiple of LANE_W");
   end
   if (LANES > DATA_W) begin : g_chk_cnt
      $error("iasc_lane_cmp: too many lanes");
   end

   logic [LANES-1:0] ge;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign ge[i] = a_i[i*LANE_W +: LANE_W] >= b_i[i*LANE_W +: LANE_W];
   end

   assign mask_o = {{(DATA_W-LANES){1'b0}}, ge};

   // R11
   always_comb begin
      lane_upper_chk: assert (mask_o[DATA_W-1:LANES] == '0);
   end

endmodule

// File: rtl/iasc_top.sv
module iasc_top
   import iasc_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LONG_W = 32,
   parameter int LANE_W = 8,
   parameter int FUNC_W = 7
) (
   input  logic [DATA_W-1:0] op_a_i,
   input  logic [DATA_W-1:0] op_b_i,
   input  logic [FUNC_W-1:0] func_i,
   output logic [DATA_W-1:0] result_o,
   output logic              ovf_o,
   output logic              illegal_o
);

   dec_t              dec;
   logic [DATA_W-1:0] arith_res;
   logic              arith_ovf;
   logic              cmp_hit;
   logic [DATA_W-1:0] lane_mask;

   iasc_decode #(.FUNC_W(FUNC_W)) u_dec (
      .func_i (func_i),
      .dec_o  (dec)
   );

   iasc_arith #(.DATA_W(DATA_W), .LONG_W(LONG_W)) u_arith (
      .a_i       (op_a_i),
      .b_i       (op_b_i),
      .is_long_i (dec.is_long),
      .is_sub_i  (dec.is_sub),
      .shamt_i   (dec.shamt),
      .res_o     (arith_res),
      .ovf_o     (arith_ovf)
   );

   iasc_compare #(.DATA_W(DATA_W)) u_cmp (
      .a_i   (op_a_i),
      .b_i   (op_b_i),
      .sel_i (dec.cmp),
      .hit_o (cmp_hit)
   );

   iasc_lane_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lane (
      .a_i    (op_a_i),
      .b_i    (op_b_i),
      .mask_o (lane_mask)
   );

   always_comb begin
      result_o  = '0;
      ovf_o     = 1'b0;
      illegal_o = 1'b0;
      case (dec.fam)
         FAM_ARITH: begin
            result_o = arith_res;
            ovf_o    = dec.trap & arith_ovf;
         end
         FAM_CMP:  result_o = {{(DATA_W-1){1'b0}}, cmp_hit};
         FAM_LANE: result_o = lane_mask;
         default:  illegal_o = 1'b1;
      endcase
   end

   // R12
   always_comb begin
      if (illegal_o) begin
         illegal_quiet_chk: assert (result_o == '0 && !ovf_o);
      end
   end

   // R7
   always_comb begin
      if (ovf_o) begin
         ovf_trap_only_chk: assert (dec.trap && !illegal_o);
      end
   end

   // R8
   always_comb begin
      if (dec.fam == FAM_CMP) begin
         cmp_bool_chk: assert (result_o[DATA_W-1:1] == '0);
      end
   end

endmodule

// File: tb/tb_iasc_top.sv
`timescale 1ns/1ps
module tb_iasc_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] a, b;
   logic [6:0]  f;
   logic [63:0] res;
   logic        ovf, ill;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 0;

   always #2 clk = ~clk;

   iasc_top dut (
      .op_a_i   (a),
      .op_b_i   (b),
      .func_i   (f),
      .result_o (res),
      .ovf_o    (ovf),
      .illegal_o(ill)
   );

   localparam logic [6:0] CODES [22] = '{
      7'h00, 7'h20, 7'h09, 7'h29, 7'h40, 7'h60, 7'h49, 7'h69,
      7'h02, 7'h22, 7'h0b, 7'h2b, 7'h12, 7'h32, 7'h1b, 7'h3b,
      7'h2d, 7'h6d, 7'h4d, 7'h3d, 7'h1d, 7'h0f };

   localparam logic [63:0] EDGE [8] = '{
      64'h0, 64'h1, 64'h7FFF_FFFF, 64'h8000_0000,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
      64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF };

   function automatic string tag_of(input logic [6:0] c);
      case (c)
         7'h00, 7'h20: return "R1";
         7'h09, 7'h29: return "R2";
         7'h02, 7'h22, 7'h0b, 7'h2b: return "R3";
         7'h12, 7'h32, 7'h1b, 7'h3b: return "R4";
         7'h40, 7'h60: return "R5";
         7'h49, 7'h69: return "R6";
         7'h2d: return "R8";
         7'h6d, 7'h4d: return "R9";
         7'h3d, 7'h1d: return "R10";
         7'h0f: return "R11";
         default: return "R12";
      endcase
   endfunction

   // behavioural reference
   function automatic void model(input logic [63:0] x, input logic [63:0] y,
                                 input logic [6:0] c, output logic [63:0] r,
                                 output logic o, output logic il);
      int  k = 0;
      bit  lng = 0, sub = 0, trp = 0, ar = 1;
      longint signed sx = x, sy = y;
      r = 0; o = 0; il = 0;
      case (c)
         7'h00: lng = 1;            7'h20: ;
         7'h09: begin lng = 1; sub = 1; end
         7'h29: sub = 1;
         7'h40: begin lng = 1; trp = 1; end
         7'h60: trp = 1;
         7'h49: begin lng = 1; sub = 1; trp = 1; end
         7'h69: begin sub = 1; trp = 1; end
         7'h02: begin lng = 1; k = 2; end
         7'h22: k = 2;
         7'h0b: begin lng = 1; sub = 1; k = 2; end
         7'h2b: begin sub = 1; k = 2; end
         7'h12: begin lng = 1; k = 3; end
         7'h32: k = 3;
         7'h1b: begin lng = 1; sub = 1; k = 3; end
         7'h3b: begin sub = 1; k = 3; end
         default: ar = 0;
      endcase
      if (ar) begin
         if (lng) begin
            logic [31:0] p, q, s;
            p = x[31:0] * (32'd1 << k);
            q = y[31:0];
            s = sub ? p - q : p + q;
            r = {{32{s[31]}}, s};
            if (trp) o = sub ? (p[31] != q[31] && s[31] != p[31])
                             : (p[31] == q[31] && s[31] != p[31]);
         end else begin
            logic [63:0] p, s;
            p = x * (64'd1 << k);
            s = sub ? p - y : p + y;
            r = s;
            if (trp) o = sub ? (p[63] != y[63] && s[63] != p[63])
                             : (p[63] == y[63] && s[63] != p[63]);
         end
      end else begin
         case (c)
            7'h2d: r = (x == y) ? 1 : 0;
            7'h6d: r = (sx <= sy) ? 1 : 0;
            7'h4d: r = (sx <  sy) ? 1 : 0;
            7'h3d: r = (x <= y) ? 1 : 0;
            7'h1d: r = (x <  y) ? 1 : 0;
            7'h0f: for (int i = 0; i < 8; i++)
                      r[i] = ((x >> (8*i)) & 64'hFF) >= ((y >> (8*i)) & 64'hFF);
            default: il = 1;
         endcase
      end
   endfunction

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string t);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s func=%h a=%h b=%h actual=%h expected=%h", t, f, a, b, act, exp);
      end
   endtask

   task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic [6:0] c);
      logic [63:0] er;
      logic        eo, ei;
      @(posedge clk);
      a = x; b = y; f = c;
      @(negedge clk);
      model(x, y, c, er, eo, ei);
      check(res, er, tag_of(c));
      // R7 for non-trapping codes, R5/R6 for trapping ones
      check({63'd0, ovf}, {63'd0, eo},
            (c == 7'h40 || c == 7'h60 || c == 7'h49 || c == 7'h69) ? tag_of(c) : "R7");
      check({63'd0, ill}, {63'd0, ei}, "R12");
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
         end
      end
   end

   initial begin
      a = '0; b = '0; f = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: zero operands, code 0 -> zero result, no flags (R1)
      @(negedge clk);
      check(res, 64'd0, "R1");
      check({63'd0, ovf | ill}, 64'd0, "R1");
      // R1 sign extension
      apply(64'h0000_0000_7FFF_FFFF, 64'h1, 7'h00);
      apply(64'h1234_0000_0000_0001, 64'h2, 7'h20);
      // R2
      apply(64'h0, 64'h1, 7'h09);
      apply(64'h5, 64'h9, 7'h29);
      // R3 / R4
      apply(64'h4000_0001, 64'h3, 7'h02);
      apply(64'h1000, 64'h1, 7'h2b);
      apply(64'h2000_0000, 64'h1, 7'h12);
      apply(64'h2000_0000_0000_0000, 64'h8, 7'h3b);
      // R5: overflow at both widths, and non-overflow
      apply(64'h7FFF_FFFF, 64'h1, 7'h40);
      apply(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 7'h60);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 7'h60);
      apply(64'h8000_0000, 64'h8000_0000, 7'h40);
      // R6
      apply(64'h8000_0000, 64'h1, 7'h49);
      apply(64'h8000_0000_0000_0000, 64'h1, 7'h69);
      apply(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 7'h69);
      apply(64'h5, 64'h5, 7'h69);
      // R7: same edge pairs on non-trapping codes
      apply(64'h7FFF_FFFF, 64'h1, 7'h00);
      apply(64'h8000_0000_0000_0000, 64'h1, 7'h29);
      // R8..R10
      apply(64'hABCD, 64'hABCD, 7'h2d);
      apply(64'hABCD, 64'h1_0000_ABCD, 7'h2d);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 7'h4d);
      apply(64'h3, 64'h3, 7'h6d);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 7'h1d);
      apply(64'h3, 64'h3, 7'h3d);
      apply(64'h3, 64'h3, 7'h1d);
      // R11
      apply(64'h00FF_7F80_0102_FE01, 64'h0100_8080_0101_FE00, 7'h0f);
      apply(64'h0, 64'h0, 7'h0f);
      // R12
      apply(64'h1234, 64'h5678, 7'h7f);
      apply(64'h7FFF_FFFF, 64'h1, 7'h01);
      // edge-value sweep over all legal codes
      foreach (CODES[ci])
         for (int ia = 0; ia < 8; ia += 3)
            for (int ib = 0; ib < 8; ib++)
               apply(EDGE[ia], EDGE[ib], CODES[ci]);
      // random
      for (int n = 0; n < 600; n++) begin
         logic [63:0] x, y;
         logic [6:0]  c;
         x = {$urandom, $urandom};
         y = {$urandom, $urandom};
         if (n % 4 == 0) x = EDGE[$urandom % 8];
         c = (n % 10 == 9) ? 7'($urandom) : CODES[$urandom % 22];
         apply(x, y, c);
      end
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule